// File: doc/BRIEF.md
# Physical Frame Sync and Slot Timer

This block does the bit-level framing of a time-slotted power-line link in which one node is the master and all others are slaves. Every bit period is marked by a single-cycle bit strobe from a clock locked to the mains. A slot is exactly one frame long: 360 bits. The frame has four parts. A 16-bit preamble 0xAAAA comes first, then the 16-bit start delimiter 0x54C7, then 38 payload bytes, then 24 trailing bits set aside for pause or alarm use. Bytes go out most significant byte first, and the bits inside each byte go out most significant bit first.

A 360-bit position counter keeps the slot timing running from one frame to the next. How that counter is first aligned depends on the node's role. A master starts its first slot on a mains zero-crossing pulse. A slave moves its slot boundary to match the master whenever it sees the 32-bit preamble-plus-delimiter pattern in the demodulated bit stream.

In the transmit direction, the block sends one frame per slot. It builds the header itself, pulls the payload bytes from a show-ahead byte source, and sends zeros for the tail. In the receive direction, it searches for the sync pattern, raises a frame-sync flag, and delivers the 38 bytes that follow, each with a valid strobe. The role input is sampled continuously and may change only while the block is held in reset. Bit strobes are at least two clock cycles apart.

Top module: `slot_frame_engine`

## Requirements
- R1: While reset is held and after it is released with idle inputs, slot_start, frame_sync, rx_byte_vld, tx_busy, tx_bit and tx_take are all 0.
- R2: In master role (master_mode=1), no slot starts before the first zc_pulse. That pulse sets the slot position to 0 and gives slot_start in the next cycle. A bit strobe in the same cycle is not counted. Any later zc_pulse is ignored.
- R3: Once running, the position advances by one on each bit strobe, modulo 360. The strobe that leaves position 359 produces a one-cycle slot_start in the next cycle.
- R4: The receiver compares the last 32 received bits, oldest in the MSB, against 0xAAAA54C7. On a match, frame_sync rises in the cycle after the completing strobe.
- R5: After a match, the next 304 bits form 38 bytes, first bit in bit 7. rx_byte_vld pulses for one cycle after every eighth bit, with the byte on rx_byte. frame_sync falls in the same cycle as the 38th pulse.
- R6: Pattern matches that occur while frame_sync is high are treated as payload data and start nothing.
- R7: In slave role (master_mode=0), zc_pulse has no effect. A match sets the position so that the next bit strobe is counted as position 32.
- R8: A match never moves the slot position in master role, or while tx_busy is high.
- R9: When a slave realignment falls on the strobe that leaves position 359, the realignment wins and no slot_start is produced.
- R10: tx_req is accepted only in a cycle in which slot_start is high and tx_busy is low. tx_busy is high from the next cycle through the cycle of the 360th strobe of that slot.
- R11: While busy, tx_bit shows the bit for the current position. Positions 0-15 carry 0xAAAA and 16-31 carry 0x54C7, both MSB first. Positions 32-335 carry the payload, MSB first. Positions 336-359 carry 0. tx_bit is 0 when not busy.
- R12: While busy, tx_take is high in each strobe cycle whose position is 31+8k for k from 0 to 37. tx_data is captured at that clock edge and becomes payload byte k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| master_mode | input | 1 | 1 = master role, 0 = slave role; static outside reset |
| zc_pulse | input | 1 | One-cycle mains zero-crossing pulse |
| bit_stb | input | 1 | One-cycle bit strobe |
| rx_bit | input | 1 | Demodulated receive bit, valid with bit_stb |
| tx_req | input | 1 | Request to send a frame in the next slot |
| tx_data | input | 8 | Head byte of the payload source |
| tx_take | output | 1 | Pops tx_data at this clock edge |
| tx_bit | output | 1 | Transmit bit for the current position |
| tx_busy | output | 1 | A frame is being sent |
| slot_start | output | 1 | One-cycle pulse at the start of a slot |
| frame_sync | output | 1 | Receiver is locked to a frame and collecting payload |
| rx_byte | output | 8 | Received payload byte |
| rx_byte_vld | output | 1 | rx_byte is valid this cycle |

## Verification
Two collisions matter most. The first is a slave realignment that lands on the same strobe as the slot counter's wrap. The bench provokes it by padding a stream with exactly enough filler bits that the last delimiter bit arrives at position 359. The reference model then expects no slot_start pulse and position 32 next. The second is a master zero crossing that coincides with a bit strobe; the zero crossing must win and the strobe must not be counted. The bench also sends a receive frame while a transmit frame is under way, in both roles, and checks that the transmitted slot timing is left alone.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam int unsigned SLOT_BITS_DEF = 360;
  localparam int unsigned SYNC_BITS_DEF = 32;
  localparam logic [31:0] SYNC_WORD_DEF = 32'hAAAA_54C7;
  localparam int unsigned PAY_BYTES_DEF = 38;
  localparam int unsigned BYTE_W_DEF    = 8;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

endpackage

// File: rtl/sfe_slot_timer.sv
module sfe_slot_timer
  import sfe_pkg::*;
#(
  parameter int unsigned SLOT_BITS = SLOT_BITS_DEF,
  parameter int unsigned SYNC_BITS = SYNC_BITS_DEF,
  parameter int unsigned POS_W     = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  role_e            role,
  input  logic             zc_pulse,
  input  logic             bit_stb,
  input  logic             realign,
  output logic [POS_W-1:0] pos_o,
  output logic             slot_start_o
);

  localparam logic [POS_W-1:0] LAST_POS  = POS_W'(SLOT_BITS - 1);
  localparam logic [POS_W-1:0] ALIGN_POS = POS_W'(SYNC_BITS);

  logic [POS_W-1:0] pos_q, pos_d;
  logic             run_q, run_d;
  logic             ss_q, ss_d;

  // next-state: zero crossing start (master), realign (slave), free run
  always_comb begin
    pos_d = pos_q;
    run_d = run_q;
    ss_d  = 1'b0;
    if (role == ROLE_MASTER && !run_q && zc_pulse) begin
      run_d = 1'b1;
      pos_d = '0;
      ss_d  = 1'b1;
    end else if (bit_stb) begin
      if (realign) begin
        run_d = 1'b1;
        pos_d = ALIGN_POS;
      end else if (run_q) begin
        if (pos_q == LAST_POS) begin
          pos_d = '0;
          ss_d  = 1'b1;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      run_q <= 1'b0;
      ss_q  <= 1'b0;
    end else begin
      pos_q <= pos_d;
      run_q <= run_d;
      ss_q  <= ss_d;
    end
  end

  assign pos_o        = pos_q;
  assign slot_start_o = ss_q;

endmodule

// File: rtl/sfe_rx_framer.sv
module sfe_rx_framer
  import sfe_pkg::*;
#(
  parameter int unsigned          SYNC_BITS = SYNC_BITS_DEF,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = SYNC_WORD_DEF,
  parameter int unsigned          PAY_BYTES = PAY_BYTES_DEF,
  parameter int unsigned          BYTE_W    = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              rx_bit,
  output logic              hit_o,
  output logic              sync_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              vld_o
);

  localparam int unsigned PAY_BITS = PAY_BYTES * BYTE_W;
  localparam int unsigned CNT_W    = $clog2(PAY_BITS + 1);
  localparam int unsigned BIT_W    = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAY_BITS);

  logic [SYNC_BITS-1:0] win_q, win_d, win_n;
  logic                 cap_q, cap_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d, cnt_inc;
  logic [BYTE_W-1:0]    byte_q, byte_d;
  logic                 vld_q, vld_d;
  logic                 hit;

  assign win_n   = {win_q[SYNC_BITS-2:0], rx_bit};
  assign cnt_inc = cnt_q + 1'b1;
  assign hit     = bit_stb && !cap_q && (win_n == SYNC_WORD);

  always_comb begin
    win_d  = win_q;
    cap_d  = cap_q;
    cnt_d  = cnt_q;
    byte_d = byte_q;
    vld_d  = 1'b0;
    if (bit_stb) begin
      win_d = win_n;
      if (cap_q) begin
        byte_d = {byte_q[BYTE_W-2:0], rx_bit};
        cnt_d  = cnt_inc;
        if (cnt_inc[BIT_W-1:0] == '0) vld_d = 1'b1;
        if (cnt_inc == CNT_LAST)      cap_d = 1'b0;
      end else if (hit) begin
        cap_d = 1'b1;
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      cap_q  <= 1'b0;
      cnt_q  <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      win_q  <= win_d;
      cap_q  <= cap_d;
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
      vld_q  <= vld_d;
    end
  end

  assign hit_o  = hit;
  assign sync_o = cap_q;
  assign byte_o = byte_q;
  assign vld_o  = vld_q;

endmodule

// File: rtl/sfe_tx_serial.sv
module sfe_tx_serial
  import sfe_pkg::*;
#(
  parameter int unsigned          SLOT_BITS = SLOT_BITS_DEF,
  parameter int unsigned          SYNC_BITS = SYNC_BITS_DEF,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = SYNC_WORD_DEF,
  parameter int unsigned          PAY_BYTES = PAY_BYTES_DEF,
  parameter int unsigned          BYTE_W    = BYTE_W_DEF,
  parameter int unsigned          POS_W     = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic [POS_W-1:0]  pos,
  input  logic              slot_start,
  input  logic              tx_req,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              take_o,
  output logic              bit_o,
  output logic              busy_o
);

  localparam int unsigned PAY_END = SYNC_BITS + PAY_BYTES * BYTE_W;
  localparam int unsigned BIT_W   = $clog2(BYTE_W);
  localparam logic [POS_W-1:0] LAST_POS    = POS_W'(SLOT_BITS - 1);
  localparam logic [POS_W-1:0] HDR_END     = POS_W'(SYNC_BITS);
  localparam logic [POS_W-1:0] PAY_STOP    = POS_W'(PAY_END);
  localparam logic [POS_W-1:0] FETCH_FIRST = POS_W'(SYNC_BITS - 1);
  localparam logic [POS_W-1:0] FETCH_STOP  = POS_W'(PAY_END - BYTE_W);

  logic              busy_q, busy_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [POS_W-1:0]  rel;
  logic              in_fetch, in_pay, take;
  logic [SYNC_BITS-1:0] hdr_sh;

  // a payload byte is popped on the strobe that enters its first bit
  assign rel      = pos - FETCH_FIRST;
  assign in_fetch = (pos >= FETCH_FIRST) && (pos < FETCH_STOP) && (rel[BIT_W-1:0] == '0);
  assign in_pay   = (pos >= HDR_END) && (pos < PAY_STOP);
  assign take     = busy_q && bit_stb && in_fetch;
  assign hdr_sh   = SYNC_WORD << pos;

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    if (busy_q && bit_stb && pos == LAST_POS) begin
      busy_d = 1'b0;
    end else if (!busy_q && slot_start && tx_req) begin
      busy_d = 1'b1;
    end
    if (take) begin
      sh_d = tx_data;
    end else if (busy_q && bit_stb && in_pay) begin
      sh_d = {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
    end
  end

  always_comb begin
    bit_o = 1'b0;
    if (busy_q) begin
      if (pos < HDR_END)  bit_o = hdr_sh[SYNC_BITS-1];
      else if (in_pay)    bit_o = sh_q[BYTE_W-1];
    end
  end

  assign take_o = take;
  assign busy_o = busy_q;

endmodule

// File: rtl/slot_frame_engine.sv
module slot_frame_engine
  import sfe_pkg::*;
#(
  parameter int unsigned          SLOT_BITS = SLOT_BITS_DEF,
  parameter int unsigned          SYNC_BITS = SYNC_BITS_DEF,
  parameter logic [SYNC_BITS-1:0] SYNC_WORD = SYNC_WORD_DEF,
  parameter int unsigned          PAY_BYTES = PAY_BYTES_DEF,
  parameter int unsigned          BYTE_W    = BYTE_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              zc_pulse,
  input  logic              bit_stb,
  input  logic              rx_bit,
  input  logic              tx_req,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_take,
  output logic              tx_bit,
  output logic              tx_busy,
  output logic              slot_start,
  output logic              frame_sync,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_byte_vld
);

  localparam int unsigned POS_W = $clog2(SLOT_BITS);

  logic [1:0]       rs_q;
  logic             rst_core_n;
  role_e            role;
  logic [POS_W-1:0] pos;
  logic             hit, realign;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  assign role    = master_mode ? ROLE_MASTER : ROLE_SLAVE;
  assign realign = hit && (role == ROLE_SLAVE) && !tx_busy;

  sfe_slot_timer #(
    .SLOT_BITS(SLOT_BITS), .SYNC_BITS(SYNC_BITS), .POS_W(POS_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_core_n), .role(role), .zc_pulse(zc_pulse),
    .bit_stb(bit_stb), .realign(realign), .pos_o(pos), .slot_start_o(slot_start)
  );

  sfe_rx_framer #(
    .SYNC_BITS(SYNC_BITS), .SYNC_WORD(SYNC_WORD),
    .PAY_BYTES(PAY_BYTES), .BYTE_W(BYTE_W)
  ) u_rx (
    .clk(clk), .rst_n(rst_core_n), .bit_stb(bit_stb), .rx_bit(rx_bit),
    .hit_o(hit), .sync_o(frame_sync), .byte_o(rx_byte), .vld_o(rx_byte_vld)
  );

  sfe_tx_serial #(
    .SLOT_BITS(SLOT_BITS), .SYNC_BITS(SYNC_BITS), .SYNC_WORD(SYNC_WORD),
    .PAY_BYTES(PAY_BYTES), .BYTE_W(BYTE_W), .POS_W(POS_W)
  ) u_tx (
    .clk(clk), .rst_n(rst_core_n), .bit_stb(bit_stb), .pos(pos),
    .slot_start(slot_start), .tx_req(tx_req), .tx_data(tx_data),
    .take_o(tx_take), .bit_o(tx_bit), .busy_o(tx_busy)
  );

endmodule

// File: rtl/sfe_checker.sv
module sfe_checker (
  input logic clk,
  input logic rst_n,
  input logic master_mode,
  input logic zc_pulse,
  input logic bit_stb,
  input logic tx_take,
  input logic tx_bit,
  input logic tx_busy,
  input logic slot_start,
  input logic frame_sync,
  input logic rx_byte_vld
);

  AST_SS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |=> !slot_start); // R3

  AST_SS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> ($past(bit_stb) || ($past(zc_pulse) && $past(master_mode)))); // R2

  AST_SLAVE_NO_ZC: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !bit_stb) |=> !slot_start); // R7

  AST_SYNC_RISE_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_sync) |-> $past(bit_stb)); // R4

  AST_VLD_FROM_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    rx_byte_vld |-> $past(frame_sync)); // R5

  AST_BUSY_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(slot_start)); // R10

  AST_BUSY_END_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(bit_stb)); // R10

  AST_IDLE_LINE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> !tx_bit); // R11

  AST_TAKE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |-> (tx_busy && bit_stb)); // R12

endmodule

bind slot_frame_engine sfe_checker u_chk (
  .clk(clk), .rst_n(rst_core_n), .master_mode(master_mode), .zc_pulse(zc_pulse),
  .bit_stb(bit_stb), .tx_take(tx_take), .tx_bit(tx_bit), .tx_busy(tx_busy),
  .slot_start(slot_start), .frame_sync(frame_sync), .rx_byte_vld(rx_byte_vld)
);

// File: tb/slot_frame_engine_test.sv
module slot_frame_engine_test;

  logic       clk = 1'b0;
  logic       rst_n, master_mode, zc_pulse, bit_stb, rx_bit, tx_req;
  logic [7:0] tx_data, rx_byte;
  logic       tx_take, tx_bit, tx_busy, slot_start, frame_sync, rx_byte_vld;

  always #4 clk = ~clk;

  slot_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode), .zc_pulse(zc_pulse),
    .bit_stb(bit_stb), .rx_bit(rx_bit), .tx_req(tx_req), .tx_data(tx_data),
    .tx_take(tx_take), .tx_bit(tx_bit), .tx_busy(tx_busy), .slot_start(slot_start),
    .frame_sync(frame_sync), .rx_byte(rx_byte), .rx_byte_vld(rx_byte_vld)
  );

  localparam logic [31:0] PAT = 32'hAAAA_54C7;

  int    checks = 0, errors = 0;
  string tag = "R1";
  logic [7:0] tx_pay [38];
  logic [7:0] rx_pay [38];
  int    tx_idx = 0;
  bit    req_hold = 1'b0;
  bit    zc_en = 1'b0;
  int    bit_no = 0;
  int    n_ss = 0, n_vld = 0, n_busy_stb = 0;

  // behavioural reference model
  int         m_pos, m_cnt;
  bit         m_run, m_ss, m_busy, m_cap, m_vld;
  logic [31:0] m_win;
  logic [7:0]  m_byte;
  bit         pss, hit, ob;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_cnt = 0; m_run = 0; m_ss = 0; m_busy = 0;
      m_cap = 0; m_vld = 0; m_win = '0; m_byte = '0;
    end else begin
      pss = m_ss; ob = m_busy; m_ss = 0; m_vld = 0; hit = 0;
      if (bit_stb) begin
        m_win = {m_win[30:0], rx_bit};
        hit = (m_win == PAT) && !m_cap;
        if (m_cap) begin
          m_byte = {m_byte[6:0], rx_bit};
          m_cnt++;
          if (m_cnt % 8 == 0) m_vld = 1;
          if (m_cnt == 304) m_cap = 0;
        end else if (hit) begin
          m_cap = 1; m_cnt = 0;
        end
      end
      if (m_busy && bit_stb && m_pos == 359) m_busy = 0;
      else if (!m_busy && pss && tx_req) m_busy = 1;
      if (master_mode && !m_run && zc_pulse) begin
        m_run = 1; m_pos = 0; m_ss = 1;
      end else if (bit_stb) begin
        if (hit && !master_mode && !ob) begin
          m_run = 1; m_pos = 32;
        end else if (m_run) begin
          if (m_pos == 359) begin m_pos = 0; m_ss = 1; end
          else m_pos++;
        end
      end
    end
  end

  function automatic void chk(string t, string sig, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", t, sig, act, exp, $time);
    end
  endfunction

  task automatic cyc(bit s, bit z, bit r);
    bit exp_bit, exp_take;
    int rel;
    @(negedge clk);
    bit_stb = s; zc_pulse = z; rx_bit = r; tx_req = req_hold;
    tx_data = (tx_idx < 38) ? tx_pay[tx_idx] : 8'h00;
    #1;
    exp_bit = 0;
    if (m_busy) begin
      if (m_pos < 32) exp_bit = PAT[31 - m_pos];
      else if (m_pos < 336) begin
        rel = m_pos - 32;
        exp_bit = tx_pay[rel / 8][7 - (rel % 8)];
      end
    end
    exp_take = m_busy && s && m_pos >= 31 && m_pos <= 327 && ((m_pos - 31) % 8 == 0);
    chk(tag,  "slot_start",  slot_start,  m_ss);
    chk("R4", "frame_sync",  frame_sync,  m_cap);
    chk("R5", "rx_byte_vld", rx_byte_vld, m_vld);
    if (m_vld) chk("R5", "rx_byte", rx_byte, m_byte);
    chk("R10", "tx_busy", tx_busy, m_busy);
    chk("R11", "tx_bit",  tx_bit,  exp_bit);
    chk("R12", "tx_take", tx_take, exp_take);
    if (exp_take) tx_idx++;
    if (!m_busy) tx_idx = 0;
    if (m_busy) req_hold = 0;
    n_ss  += slot_start;
    n_vld += rx_byte_vld;
    if (tx_busy && s) n_busy_stb++;
  endtask

  task automatic bitx(bit r);
    cyc(1'b1, 1'b0, r);
    cyc(1'b0, zc_en && (bit_no % 24 == 0), 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    bit_no++;
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) bitx(v[i]);
  endtask

  task automatic send_frame();
    send_byte(8'hAA); send_byte(8'hAA); send_byte(8'h54); send_byte(8'hC7);
    for (int i = 0; i < 38; i++) send_byte(rx_pay[i]);
  endtask

  task automatic zeros(int n);
    for (int i = 0; i < n; i++) bitx(1'b0);
  endtask

  task automatic do_reset(bit role);
    rst_n = 0; master_mode = role; bit_stb = 0; zc_pulse = 0; rx_bit = 0;
    tx_req = 0; tx_data = 0; req_hold = 0; zc_en = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (6) cyc(1'b0, 1'b0, 1'b0);
    n_ss = 0; n_vld = 0; n_busy_stb = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, all requirements unfinished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int ss_before;

  initial begin
    for (int i = 0; i < 38; i++) begin
      tx_pay[i] = 8'(i * 29 + 7);
      rx_pay[i] = 8'(i * 13 + 91);
    end
    rx_pay[5] = 8'hAA; rx_pay[6] = 8'hAA; rx_pay[7] = 8'h54; rx_pay[8] = 8'hC7;

    // R1: reset state, master role
    do_reset(1'b1);
    tag = "R1";
    chk("R1", "slot_start",  slot_start, 0);
    chk("R1", "frame_sync",  frame_sync, 0);
    chk("R1", "rx_byte_vld", rx_byte_vld, 0);
    chk("R1", "tx_busy",     tx_busy, 0);
    chk("R1", "tx_bit",      tx_bit, 0);
    chk("R1", "tx_take",     tx_take, 0);

    // R2: nothing before the first zero crossing, then zc beats a strobe
    tag = "R2";
    zeros(20);
    chk("R2", "slot_start count before zc", n_ss, 0);
    cyc(1'b1, 1'b1, 1'b0);
    cyc(1'b0, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b0); cyc(1'b0, 1'b0, 1'b0);
    chk("R2", "slot_start count after zc", n_ss, 1);

    // R3: free run with later zero crossings ignored
    tag = "R3";
    zc_en = 1; bit_no = 1;
    zeros(100);

    // R10/R11/R12 transmit, with R6/R8 receive in master role alongside
    tag = "R8";
    req_hold = 1;
    zeros(13);
    tag = "R6";
    send_frame();
    tag = "R3";
    zeros(400);
    chk("R5", "payload bytes received", n_vld, 38);
    chk("R10", "strobes while busy", n_busy_stb, 360);

    // R7: slave role, zero crossings ignored, realign to position 32
    do_reset(1'b0);
    tag = "R7";
    zc_en = 1; bit_no = 1;
    zeros(30);
    chk("R7", "slot_start count before match", n_ss, 0);
    zc_en = 0;
    zeros(10);
    send_frame();
    // R9: realign lands on the wrap strobe
    tag = "R9";
    zeros(352);
    ss_before = n_ss;
    send_byte(8'hAA); send_byte(8'hAA); send_byte(8'h54); send_byte(8'hC7);
    chk("R9", "slot_start during coincident realign", n_ss - ss_before, 0);
    for (int i = 0; i < 38; i++) send_byte(rx_pay[i]);

    // R8: match while busy leaves slot timing alone
    tag = "R8";
    n_busy_stb = 0;
    req_hold = 1;
    zeros(44);
    send_frame();
    zeros(400);
    chk("R10", "strobes while busy (slave)", n_busy_stb, 360);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule